// File: doc/BRIEF.md
# Partitioned Register Read Compactor

This block is the read path of a physical register file in which every 64-bit entry is divided into four 16-bit partitions. A narrow result can occupy only some of those partitions, and they need not be adjacent. A read presents a register index and a 4-bit parts mask. The block collects the selected partitions, lowest first, into a right-aligned value. It then fills every unused upper chunk with the most significant bit of the highest selected partition, so consumers always receive a full-width, sign-extended operand.

Output chunk 0 can come from any partition. Each higher output chunk chooses from a set of candidate partitions one smaller than the chunk below it. A separate selector picks the sign bit. To make the block testable, a synchronous write port is included. It takes a right-aligned value and a mask, and scatters the value's low chunks into the partitions the mask names. Read results appear one clock after the request.

Top module: `regpack_read_compactor`

## Requirements
- R1: After the synchronous active-low reset, `rd_valid` is 0, `rd_data` is 0, and every register reads back as zero.
- R2: A read accepted on a rising edge (`rd_en` high) produces `rd_valid` high on the next edge, with its data. With no read there is no `rd_valid`, and results come back in request order.
- R3: With mask 4'b1111 the read returns the stored 64-bit word unchanged.
- R4: Partition p occupies bits [16p+15:16p] of the stored word, and mask bit p selects partition p. Output chunk i (bits [16i+15:16i]) is taken from the partition of the (i+1)-th set mask bit, counting upward from bit 0.
- R5: Selected partitions may be non-adjacent. With mask 4'b1001, partition 0 gives output chunk 0 and partition 3 gives output chunk 1.
- R6: Output chunks at or above the number of set mask bits are all copies of bit 15 of the highest selected partition.
- R7: A read with mask 4'b0000 returns zero.
- R8: A write (`wr_en` high) puts chunk j of `wr_data` into the partition of the (j+1)-th set bit of `wr_mask`. Partitions whose mask bit is clear keep their contents.
- R9: A write with mask 4'b0000 changes no register.
- R10: A read and a write to the same register on the same edge return the contents from before that write.
- R11: `rd_data` is zero on every cycle where `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register written |
| wr_mask | input | 4 | Partitions written |
| wr_data | input | 64 | Right-aligned value to scatter |
| rd_en | input | 1 | Read request |
| rd_idx | input | 4 | Register read |
| rd_mask | input | 4 | Partitions gathered |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Compacted, sign-extended read value |

## Verification
The checker watches four things on every cycle: the one-cycle timing of `rd_valid`, the zero data on idle cycles, the zero result for an empty mask, and the rule that a single-partition read has upper bits that are all equal. The scoreboard covers what needs the stored contents. That includes the order in which chunks are gathered for every mask, the scattered placement on writes and the preservation of unselected partitions. It also covers the ignored empty-mask write and the old-data result when a read and a write hit the same register on the same edge.

// File: rtl/regpack_pkg.sv
// Package: shared geometry of the partitioned register file.
// Assumes the partition count is small (a handful), so rank logic stays shallow.
package regpack_pkg;
    localparam int unsigned PART_W    = 16;
    localparam int unsigned NUM_PARTS = 4;
    localparam int unsigned NUM_REGS  = 16;
    localparam int unsigned DATA_W    = PART_W * NUM_PARTS;
endpackage

// File: rtl/regpack_rank.sv
// Module: regpack_rank
// For each partition, counts the set mask bits below it (its rank among
// selected partitions), and also counts all set bits. Pure combinational.
// Assumes NUM_PARTS >= 1.
module regpack_rank #(
    parameter int unsigned NUM_PARTS = regpack_pkg::NUM_PARTS,
    localparam int unsigned CNT_W    = $clog2(NUM_PARTS + 1)
) (
    input  logic [NUM_PARTS-1:0]            mask,
    output logic [NUM_PARTS-1:0][CNT_W-1:0] rank,
    output logic [CNT_W-1:0]                total
);
    // Prefix population count: rank[p] = number of set bits in mask[p-1:0].
    always_comb begin
        for (int p = 0; p < NUM_PARTS; p++) begin
            rank[p] = '0;
            for (int q = 0; q < p; q++) begin
                rank[p] = rank[p] + CNT_W'(mask[q]);
            end
        end
    end

    // Total number of selected partitions.
    always_comb begin
        total = '0;
        for (int p = 0; p < NUM_PARTS; p++) begin
            total = total + CNT_W'(mask[p]);
        end
    end
endmodule

// File: rtl/regpack_scatter.sv
// Module: regpack_scatter
// Write-side spreader: routes chunk j of a right-aligned value to the
// partition holding the (j+1)-th set mask bit. It produces per-partition write
// enables and data. Assumes rank values are below NUM_PARTS for set bits.
module regpack_scatter #(
    parameter int unsigned PART_W    = regpack_pkg::PART_W,
    parameter int unsigned NUM_PARTS = regpack_pkg::NUM_PARTS,
    localparam int unsigned DATA_W   = PART_W * NUM_PARTS,
    localparam int unsigned CNT_W    = $clog2(NUM_PARTS + 1)
) (
    input  logic [NUM_PARTS-1:0] mask,
    input  logic [DATA_W-1:0]    value,
    output logic [NUM_PARTS-1:0] part_we,
    output logic [DATA_W-1:0]    part_data
);
    logic [NUM_PARTS-1:0][CNT_W-1:0] rank;
    logic [CNT_W-1:0]                total_unused;

    regpack_rank #(.NUM_PARTS(NUM_PARTS)) u_rank (
        .mask  (mask),
        .rank  (rank),
        .total (total_unused)
    );

    // One selector per physical partition, picking the value chunk of its rank.
    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        always_comb begin
            part_data[p*PART_W +: PART_W] = '0;
            for (int j = 0; j <= p; j++) begin
                if (rank[p] == CNT_W'(j)) begin
                    part_data[p*PART_W +: PART_W] = value[j*PART_W +: PART_W];
                end
            end
        end
        assign part_we[p] = mask[p];
    end
endmodule

// File: rtl/regpack_storage.sv
// Module: regpack_storage
// Register array with per-partition write enables and one asynchronous read
// port. A read of the register being written returns the old contents.
// Reset clears every entry (synchronous, active low).
module regpack_storage #(
    parameter int unsigned NUM_REGS  = regpack_pkg::NUM_REGS,
    parameter int unsigned PART_W    = regpack_pkg::PART_W,
    parameter int unsigned NUM_PARTS = regpack_pkg::NUM_PARTS,
    localparam int unsigned DATA_W   = PART_W * NUM_PARTS,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     widx,
    input  logic [NUM_PARTS-1:0] part_we,
    input  logic [DATA_W-1:0]    part_data,
    input  logic [IDX_W-1:0]     ridx,
    output logic [DATA_W-1:0]    rword
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    // Clear on reset, otherwise update only the enabled partitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                mem[r] <= '0;
            end
        end else if (we) begin
            for (int p = 0; p < NUM_PARTS; p++) begin
                if (part_we[p]) begin
                    mem[widx][p*PART_W +: PART_W] <= part_data[p*PART_W +: PART_W];
                end
            end
        end
    end

    // Asynchronous read of the addressed entry.
    assign rword = mem[ridx];
endmodule

// File: rtl/regpack_gather.sv
// Module: regpack_gather
// Read-side compactor. Output chunk i uses a selector over partitions i and up,
// so each higher chunk has one candidate fewer. It takes the partition whose
// rank equals i. A separate selector takes the top bit of the highest selected
// partition and fills the chunks above the selected count with it.
// An empty mask gives zero.
module regpack_gather #(
    parameter int unsigned PART_W    = regpack_pkg::PART_W,
    parameter int unsigned NUM_PARTS = regpack_pkg::NUM_PARTS,
    localparam int unsigned DATA_W   = PART_W * NUM_PARTS,
    localparam int unsigned CNT_W    = $clog2(NUM_PARTS + 1)
) (
    input  logic [DATA_W-1:0]    word,
    input  logic [NUM_PARTS-1:0] mask,
    output logic [DATA_W-1:0]    value
);
    logic [NUM_PARTS-1:0][CNT_W-1:0] rank;
    logic [CNT_W-1:0]                total;
    logic                            sign_bit;

    regpack_rank #(.NUM_PARTS(NUM_PARTS)) u_rank (
        .mask  (mask),
        .rank  (rank),
        .total (total)
    );

    // Sign selector: the last set bit scanned upward is the highest one.
    always_comb begin
        sign_bit = 1'b0;
        for (int p = 0; p < NUM_PARTS; p++) begin
            if (mask[p]) begin
                sign_bit = word[p*PART_W + PART_W - 1];
            end
        end
    end

    // Shrinking selectors: chunk i only considers partitions i..NUM_PARTS-1.
    for (genvar i = 0; i < NUM_PARTS; i++) begin : g_chunk
        logic [PART_W-1:0] picked;
        always_comb begin
            picked = '0;
            for (int p = i; p < NUM_PARTS; p++) begin
                if (mask[p] && rank[p] == CNT_W'(i)) begin
                    picked = word[p*PART_W +: PART_W];
                end
            end
        end
        assign value[i*PART_W +: PART_W] =
            (CNT_W'(i) < total) ? picked : {PART_W{sign_bit}};
    end
endmodule

// File: rtl/regpack_read_compactor.sv
// Module: regpack_read_compactor (top)
// A partitioned register file with a compacting, sign-extending read and a
// scattering write. The read result is registered: it is valid one clock
// after rd_en and zero while no result is valid. Synchronous active-low reset.
module regpack_read_compactor #(
    parameter int unsigned NUM_REGS  = regpack_pkg::NUM_REGS,
    parameter int unsigned PART_W    = regpack_pkg::PART_W,
    parameter int unsigned NUM_PARTS = regpack_pkg::NUM_PARTS,
    localparam int unsigned DATA_W   = PART_W * NUM_PARTS,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [NUM_PARTS-1:0] wr_mask,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [NUM_PARTS-1:0] rd_mask,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data
);
    logic [NUM_PARTS-1:0] part_we;
    logic [DATA_W-1:0]    part_data;
    logic [DATA_W-1:0]    raw_word;
    logic [DATA_W-1:0]    packed_val;

    regpack_scatter #(.PART_W(PART_W), .NUM_PARTS(NUM_PARTS)) u_scatter (
        .mask      (wr_mask),
        .value     (wr_data),
        .part_we   (part_we),
        .part_data (part_data)
    );

    regpack_storage #(.NUM_REGS(NUM_REGS), .PART_W(PART_W), .NUM_PARTS(NUM_PARTS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .widx      (wr_idx),
        .part_we   (part_we),
        .part_data (part_data),
        .ridx      (rd_idx),
        .rword     (raw_word)
    );

    regpack_gather #(.PART_W(PART_W), .NUM_PARTS(NUM_PARTS)) u_gather (
        .word  (raw_word),
        .mask  (rd_mask),
        .value (packed_val)
    );

    // Output register: capture the compacted value on a read, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? packed_val : '0;
        end
    end
endmodule

// File: rtl/regpack_chk.sv
// Module: regpack_chk
// Port-level properties of the compactor, bound into every instance of the top.
module regpack_chk #(
    parameter int unsigned PART_W    = regpack_pkg::PART_W,
    parameter int unsigned NUM_PARTS = regpack_pkg::NUM_PARTS,
    localparam int unsigned DATA_W   = PART_W * NUM_PARTS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic [NUM_PARTS-1:0] rd_mask,
    input logic                 rd_valid,
    input logic [DATA_W-1:0]    rd_data
);
    // R2
    read_valid_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R2
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R11
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

    // R7
    empty_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_mask == '0) |=> rd_data == '0);

    // R6
    single_part_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $countones(rd_mask) == 1) |=>
        (rd_data[DATA_W-1:PART_W-1] == '0 || rd_data[DATA_W-1:PART_W-1] == '1));
endmodule

bind regpack_read_compactor regpack_chk #(.PART_W(PART_W), .NUM_PARTS(NUM_PARTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_mask  (rd_mask),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/sim_regpack_read_compactor.sv
module sim_regpack_read_compactor;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [3:0]  wr_mask = '0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [3:0]  rd_mask = '0;
    logic        rd_valid;
    logic [63:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    logic [63:0] model [16];
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    regpack_read_compactor u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_mask(rd_mask),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Expected read: selected chunks packed low, rest filled with the sign.
    function automatic logic [63:0] gather_ref(logic [63:0] w, logic [3:0] m);
        logic [63:0] v = '0;
        int n = 0;
        logic s = 1'b0;
        for (int p = 0; p < 4; p++) begin
            if (m[p]) begin
                v[n*16 +: 16] = w[p*16 +: 16];
                s = w[p*16 + 15];
                n++;
            end
        end
        for (int i = n; i < 4; i++) v[i*16 +: 16] = {16{s}};
        return v;
    endfunction

    // Expected write: chunk j goes to the (j+1)-th selected partition.
    function automatic logic [63:0] scatter_ref(logic [63:0] old, logic [63:0] d, logic [3:0] m);
        int n = 0;
        for (int p = 0; p < 4; p++) begin
            if (m[p]) begin
                old[p*16 +: 16] = d[n*16 +: 16];
                n++;
            end
        end
        return old;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one cycle of optional write and optional read, pushing the expectation.
    task automatic op(input bit we, input logic [3:0] wi, input logic [3:0] wm, input logic [63:0] wd,
                      input bit re, input logic [3:0] ri, input logic [3:0] rm, input string tag);
        if (re) begin
            exp_q.push_back(gather_ref(model[ri], rm));
            tag_q.push_back(tag);
        end
        if (we) model[wi] = scatter_ref(model[wi], wd, wm);
        wr_en = we; wr_idx = wi; wr_mask = wm; wr_data = wd;
        rd_en = re; rd_idx = ri; rd_mask = rm;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ri, input logic [3:0] rm, input string tag);
        op(1'b0, 4'd0, 4'd0, 64'd0, 1'b1, ri, rm, tag);
    endtask

    task automatic wr(input logic [3:0] wi, input logic [3:0] wm, input logic [63:0] wd);
        op(1'b1, wi, wm, wd, 1'b0, 4'd0, 4'd0, "");
    endtask

    // Monitor: compare each valid result with the head of the scoreboard.
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected valid", rd_data, 64'd0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rd_data === e, t, rd_data, e);
                end
            end else begin
                check(rd_data === 64'd0, "R11", rd_data, 64'd0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 16; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(rd_valid === 1'b0, "R1 rd_valid", {63'd0, rd_valid}, 64'd0);
        check(rd_data === 64'd0, "R1 rd_data", rd_data, 64'd0);
        mon_on = 1'b1;
        // R1: every register cleared
        for (int r = 0; r < 16; r++) rd(4'(r), 4'b1111, "R1");

        // R3: full-mask round trip; R2: back-to-back reads
        wr(4'd3, 4'b1111, 64'h8123_4567_89AB_CDEF);
        rd(4'd3, 4'b1111, "R3");
        rd(4'd3, 4'b1111, "R2");
        // R5: non-adjacent partitions 0 and 3
        rd(4'd3, 4'b1001, "R5");
        // R7: empty mask
        rd(4'd3, 4'b0000, "R7");
        // R4: every mask value
        for (int m = 0; m < 16; m++) rd(4'd3, 4'(m), "R4");

        // R6: sign from the highest selected partition
        wr(4'd9, 4'b1111, 64'h7FFF_8000_0123_FEDC);
        rd(4'd9, 4'b0001, "R6");
        rd(4'd9, 4'b0010, "R6");
        rd(4'd9, 4'b0100, "R6");
        rd(4'd9, 4'b1100, "R6");
        rd(4'd9, 4'b0101, "R6");

        // R8: narrow scatter write leaves other partitions intact
        wr(4'd5, 4'b1111, 64'hAAAA_BBBB_CCCC_DDDD);
        wr(4'd5, 4'b1010, 64'h0000_0000_7777_1234);
        rd(4'd5, 4'b1111, "R8");
        rd(4'd5, 4'b1010, "R8");
        wr(4'd6, 4'b0100, 64'h0000_0000_0000_9001);
        rd(4'd6, 4'b1111, "R8");

        // R9: empty-mask write changes nothing
        wr(4'd5, 4'b0000, 64'h1111_2222_3333_4444);
        rd(4'd5, 4'b1111, "R9");

        // R10: same-edge write and read return pre-write contents
        op(1'b1, 4'd7, 4'b1111, 64'h0BAD_F00D_1234_5678, 1'b1, 4'd7, 4'b1111, "R10");
        rd(4'd7, 4'b1111, "R10");

        // R2: idle cycles bring no valid
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 queue drained", 64'(exp_q.size()), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule